// File: doc/BRIEF.md
# Command-Port Watchdog Timer

This block is a watchdog peripheral that a host reaches through a window of two byte-wide ports on a simple synchronous bus with one write strobe and one read strobe. Port offset 1 takes single-byte commands; port offset 0 carries data in both directions. Commands arm, disarm and refresh the watchdog, ask the block to identify itself, or open an indirect write through which two 16-bit delays are loaded: an arming delay and a timeout.

Once armed, the block first waits out the arming delay and then counts the timeout down in ticks of 100 ms. The tick length is set in clock cycles by a parameter, so a bench can use a short one. If the host does not refresh the count before it runs out, the block drives a reset pulse of fixed length and then returns to the idle state. A host that wants a timeout of 1 to 6000 seconds writes a timeout of 10 to 60000 ticks.

Top module: `cmdport_watchdog`

## Requirements
- R1: After a synchronous active-low reset, `wd_reset_o` is low, `bus_rdata` is 0x00, the watchdog is idle and both delays are zero.
- R2: A command byte 0x30 makes the next read of the data port (offset 0) return 0x95. Later reads return 0x00. Any other command byte written before that read cancels the pending answer. Read data appears on `bus_rdata` one cycle after the read strobe.
- R3: Command 0x89 opens an indirect write. The next data-port write is taken as an index and the data-port write after that as the value. Index 0x5E is the high byte and index 0x5F the low byte of the 16-bit timeout. Index 0x58 is the high byte and index 0x59 the low byte of the 16-bit arming delay. A value sent to any other index is discarded.
- R4: A data-port write when no indirect write is open has no effect. Any command byte abandons an indirect write that is not finished.
- R5: Command 0x28 arms the watchdog, loading the timeout that was written most recently. With an arming delay of zero and a timeout of N, `wd_reset_o` rises N*TICK_CYC cycles after the edge that took the command. A timeout of zero behaves as one tick.
- R6: `wd_reset_o` stays high for exactly RST_CYC cycles. The watchdog is then idle and does not fire again until it is armed again.
- R7: Command 0x2A (refresh) while counting reloads the timeout and restarts the tick phase. The pulse then follows N*TICK_CYC cycles after the refresh edge.
- R8: Command 0x29 returns the watchdog to idle from any phase and drops any reset pulse. A refresh while idle has no effect.
- R9: A nonzero arming delay M puts M*TICK_CYC cycles of waiting ahead of the timeout count, so the pulse rises (M+N)*TICK_CYC cycles after the arming edge.
- R10: Writing the timeout while the watchdog runs does not change the count in progress. The new value, including zero, applies from the next arm or refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Byte write strobe, one cycle per access |
| bus_rd | input | 1 | Byte read strobe, one cycle per access |
| bus_addr | input | 1 | Port select: 0 selects the data port, 1 the command port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| wd_reset_o | output | 1 | Reset pulse raised on timeout |

## Verification
The hardest situation to reach is one where configuration traffic lands in the middle of a countdown or an unfinished indirect write. Examples are a timeout of zero written while the count runs, a command that cuts off an indirect write between its index and its value, and a disarm during the arming delay. The stimulus interleaves these bus sequences at chosen cycle offsets from the arming edge. It then judges each case only by the exact edge at which the reset pulse rises, or by the absence of a pulse over a window several timeouts long. Refreshes are placed at tick phases that are not whole multiples, so that a tick prescaler that keeps running through a refresh shows up as a misplaced pulse.

// File: rtl/cpw_pkg.sv
// Package: shared codes, state types and the index-to-slot map.
// Assumes byte-wide ports and 16-bit delay registers built from two bytes.
package cpw_pkg;
    localparam int BYTE_W = 8;
    localparam int DLY_W  = 2 * BYTE_W;
    localparam int NSLOT  = 4;

    localparam logic [7:0] OP_IDENT = 8'h30;
    localparam logic [7:0] OP_START = 8'h28;
    localparam logic [7:0] OP_STOP  = 8'h29;
    localparam logic [7:0] OP_KICK  = 8'h2A;
    localparam logic [7:0] OP_INDIR = 8'h89;
    localparam logic [7:0] SIG_BYTE = 8'h95;

    localparam logic [7:0] IX_ARM_HI = 8'h58;
    localparam logic [7:0] IX_ARM_LO = 8'h59;
    localparam logic [7:0] IX_TMO_HI = 8'h5E;
    localparam logic [7:0] IX_TMO_LO = 8'h5F;

    localparam logic PORT_DATA = 1'b0;
    localparam logic PORT_CMD  = 1'b1;

    typedef enum logic [1:0] {SQ_IDLE, SQ_INDEX, SQ_VALUE} seq_t;
    typedef enum logic [1:0] {WD_OFF, WD_ARM, WD_RUN, WD_FIRE} wd_t;

    // Maps an indirect index to a byte slot: 0/1 timeout lo/hi, 2/3 arming lo/hi, 4 none.
    function automatic logic [2:0] slot_of(input logic [7:0] ix);
        case (ix)
            IX_TMO_LO: slot_of = 3'd0;
            IX_TMO_HI: slot_of = 3'd1;
            IX_ARM_LO: slot_of = 3'd2;
            IX_ARM_HI: slot_of = 3'd3;
            default:   slot_of = 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/cpw_decode.sv
// Command decoder and indirect register file.
// Turns command-port writes into one-cycle operation pulses, runs the
// index/value sequence on the data port and answers the identify query.
// Assumes a read and a write never share a cycle.
module cpw_decode
    import cpw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             start_p,
    output logic             stop_p,
    output logic             kick_p,
    output logic [DLY_W-1:0] tmo_dly,
    output logic [DLY_W-1:0] arm_dly
);
    logic       cmd_wr, dat_wr, dat_rd, val_wr;
    seq_t       seq_q;
    logic [7:0] idx_q;
    logic       id_pend_q;
    logic [7:0] slot_q [NSLOT];

    // Strobe qualification by port.
    always_comb begin
        cmd_wr  = bus_wr && (bus_addr == PORT_CMD);
        dat_wr  = bus_wr && (bus_addr == PORT_DATA);
        dat_rd  = bus_rd && (bus_addr == PORT_DATA);
        val_wr  = dat_wr && (seq_q == SQ_VALUE);
        start_p = cmd_wr && (bus_wdata == OP_START);
        stop_p  = cmd_wr && (bus_wdata == OP_STOP);
        kick_p  = cmd_wr && (bus_wdata == OP_KICK);
    end

    // Indirect write sequencer: command opens it, index then value close it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= SQ_IDLE;
            idx_q <= '0;
        end else if (cmd_wr) begin
            seq_q <= (bus_wdata == OP_INDIR) ? SQ_INDEX : SQ_IDLE;
        end else if (dat_wr) begin
            case (seq_q)
                SQ_INDEX: begin
                    idx_q <= bus_wdata;
                    seq_q <= SQ_VALUE;
                end
                SQ_VALUE: seq_q <= SQ_IDLE;
                default:  seq_q <= SQ_IDLE;
            endcase
        end
    end

    // Byte slots of the two delay registers.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (val_wr && (slot_of(idx_q) == 3'(g)))
                slot_q[g] <= bus_wdata;
        end
    end

    assign tmo_dly = {slot_q[1], slot_q[0]};
    assign arm_dly = {slot_q[3], slot_q[2]};

    // Identify answer: armed by the query, spent by a data read or another command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            id_pend_q <= 1'b0;
        else if (cmd_wr)
            id_pend_q <= (bus_wdata == OP_IDENT);
        else if (dat_rd)
            id_pend_q <= 1'b0;
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (dat_rd)
            bus_rdata <= id_pend_q ? SIG_BYTE : 8'h00;
        else if (bus_rd)
            bus_rdata <= 8'h00;
    end

    p_ident_sig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_rd && id_pend_q) |=> (bus_rdata == SIG_BYTE));
    p_seq_abandon_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (seq_q != SQ_VALUE));
    p_stray_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && seq_q == SQ_IDLE) |=> ($stable(tmo_dly) && $stable(arm_dly)));
    p_one_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_p, stop_p, kick_p}));
endmodule

// File: rtl/cpw_prescale.sv
// Tick prescaler: one-cycle tick every TICK_CYC cycles while run is high.
// Cleared by clr and held at zero while idle, so each arm or refresh starts
// a full tick period.
module cpw_prescale #(
    parameter int TICK_CYC = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(TICK_CYC - 1));

    // Cycle counter within one tick period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    if (TICK_CYC > 1) begin : g_chk
        p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
        p_tick_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> !tick);
    end
endmodule

// File: rtl/cpw_countdown.sv
// Watchdog phase machine: idle, arming wait, timeout count, reset pulse.
// Assumes at most one of start/stop/kick per cycle and a tick from
// cpw_prescale that this block runs and clears.
module cpw_countdown
    import cpw_pkg::*;
#(
    parameter int RST_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_p,
    input  logic             stop_p,
    input  logic             kick_p,
    input  logic             tick,
    input  logic [DLY_W-1:0] tmo_dly,
    input  logic [DLY_W-1:0] arm_dly,
    output logic             run_o,
    output logic             clr_o,
    output logic             wd_reset_o
);
    localparam int FW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

    wd_t              st_q;
    logic [DLY_W-1:0] cnt_q;
    logic [FW-1:0]    fcnt_q;

    // Prescaler control and pulse output from the phase.
    always_comb begin
        run_o      = (st_q == WD_ARM) || (st_q == WD_RUN);
        clr_o      = start_p || (kick_p && st_q == WD_RUN);
        wd_reset_o = (st_q == WD_FIRE);
    end

    // Phase transitions and the shared down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n || stop_p) begin
            st_q   <= WD_OFF;
            cnt_q  <= '0;
            fcnt_q <= '0;
        end else if (start_p) begin
            fcnt_q <= '0;
            if (arm_dly != '0) begin
                st_q  <= WD_ARM;
                cnt_q <= arm_dly;
            end else begin
                st_q  <= WD_RUN;
                cnt_q <= tmo_dly;
            end
        end else begin
            case (st_q)
                WD_ARM: if (tick) begin
                    if (cnt_q <= DLY_W'(1)) begin
                        st_q  <= WD_RUN;
                        cnt_q <= tmo_dly;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                WD_RUN: begin
                    if (kick_p)
                        cnt_q <= tmo_dly;
                    else if (tick) begin
                        if (cnt_q <= DLY_W'(1)) begin
                            st_q   <= WD_FIRE;
                            cnt_q  <= '0;
                            fcnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                WD_FIRE: begin
                    if (fcnt_q == FW'(RST_CYC - 1))
                        st_q <= WD_OFF;
                    else
                        fcnt_q <= fcnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> (!wd_reset_o && !run_o));
    p_kick_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WD_OFF && kick_p && !start_p) |=> (st_q == WD_OFF));
    p_fire_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_reset_o) |-> $past(tick));
    p_pulse_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wd_reset_o) && !$past(stop_p) && !$past(start_p)) |-> (st_q == WD_OFF));
    p_arm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WD_ARM && !tick && !stop_p && !start_p) |=> (st_q == WD_ARM));
endmodule

// File: rtl/cmdport_watchdog.sv
// Top: command-port watchdog. Joins the decoder, the prescaler and the
// phase machine. TICK_CYC is clock cycles per 100 ms tick; RST_CYC is
// the length of the reset pulse.
module cmdport_watchdog #(
    parameter int TICK_CYC = 25_000_000,
    parameter int RST_CYC  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       wd_reset_o
);
    import cpw_pkg::*;

    logic             start_p, stop_p, kick_p, tick, run, clr;
    logic [DLY_W-1:0] tmo_dly, arm_dly;

    cpw_decode u_dec (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .start_p(start_p), .stop_p(stop_p), .kick_p(kick_p),
        .tmo_dly(tmo_dly), .arm_dly(arm_dly)
    );

    cpw_prescale #(.TICK_CYC(TICK_CYC)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .tick(tick)
    );

    cpw_countdown #(.RST_CYC(RST_CYC)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start_p(start_p), .stop_p(stop_p),
        .kick_p(kick_p), .tick(tick), .tmo_dly(tmo_dly), .arm_dly(arm_dly),
        .run_o(run), .clr_o(clr), .wd_reset_o(wd_reset_o)
    );
endmodule

// File: tb/cmdport_watchdog_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected read bytes and pulse edges;
// monitor processes pop and compare them as the design responds.
module cmdport_watchdog_tb_top;
    localparam int T = 8;
    localparam int R = 4;

    typedef struct { int val; string tag; } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wd_reset_o;

    int   cyc = 0, checks = 0, errors = 0, n_rise = 0, hi_len = 0;
    logic rd_seen = 1'b0, rst_prev = 1'b0;
    exp_t rd_q[$];
    exp_t fire_q[$];

    cmdport_watchdog #(.TICK_CYC(T), .RST_CYC(R)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wd_reset_o(wd_reset_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        rd_seen <= bus_rd && rst_n;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: read data and reset pulses against the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_seen) begin
                exp_t e;
                if (rd_q.size() == 0) chk(0, "R2 unexpected read", 0, 0);
                else begin
                    e = rd_q.pop_front();
                    chk(bus_rdata == e.val[7:0], e.tag, int'(bus_rdata), e.val);
                end
            end
            if (wd_reset_o && !rst_prev) begin
                exp_t e;
                n_rise++;
                hi_len = 0;
                if (fire_q.size() == 0) chk(0, "R8 unexpected pulse at cycle", cyc, -1);
                else begin
                    e = fire_q.pop_front();
                    chk(cyc == e.val, e.tag, cyc, e.val);
                end
            end
            if (wd_reset_o) hi_len++;
            if (!wd_reset_o && rst_prev) chk(hi_len == R, "R6 pulse length", hi_len, R);
            rst_prev = wd_reset_o;
        end
    end

    task automatic wr(input logic a, input logic [7:0] d, output int e);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; e = cyc + 1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] d, output int e);
        wr(1'b1, d, e);
    endtask

    task automatic rd_data(input int expv, input string tag);
        @(negedge clk);
        rd_q.push_back('{expv, tag});
        bus_rd = 1'b1; bus_addr = 1'b0;
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_reg(input logic [7:0] ix, input logic [7:0] v);
        int e;
        cmd(8'h89, e);
        wr(1'b0, ix, e);
        wr(1'b0, v, e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : main
        int e, ek, base;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wd_reset_o == 1'b0, "R1 reset pulse low", int'(wd_reset_o), 0);
        chk(bus_rdata == 8'h00, "R1 read data zero", int'(bus_rdata), 0);

        // R2 identify, one-shot, cancelled by another command
        cmd(8'h30, e);
        rd_data(8'h95, "R2 signature");
        rd_data(8'h00, "R2 second read");
        cmd(8'h30, e);
        cmd(8'h2A, e);
        rd_data(8'h00, "R2 cancelled by command");

        // R3/R5 timeout of 3 ticks
        set_reg(8'h5F, 8'd3);
        cmd(8'h28, e);
        fire_q.push_back('{e + 3*T, "R5 pulse edge N=3"});
        idle(40);

        // R9 arming delay of 2 ticks
        set_reg(8'h59, 8'd2);
        cmd(8'h28, e);
        fire_q.push_back('{e + 5*T, "R9 pulse edge M=2 N=3"});
        idle(55);
        set_reg(8'h59, 8'd0);

        // R7 refresh at an odd tick phase
        cmd(8'h28, e);
        idle(10);
        cmd(8'h2A, ek);
        fire_q.push_back('{ek + 3*T, "R7 pulse after refresh"});
        idle(35);

        // R4 stray data writes ignored
        wr(1'b0, 8'h5E, e);
        wr(1'b0, 8'h05, e);
        cmd(8'h28, e);
        fire_q.push_back('{e + 3*T, "R4 stray data ignored"});
        idle(35);

        // R4 command abandons an open indirect write
        cmd(8'h89, e);
        wr(1'b0, 8'h5F, e);
        cmd(8'h30, e);
        wr(1'b0, 8'h09, e);
        rd_data(8'h95, "R2 identify after abandoned write");
        cmd(8'h28, e);
        fire_q.push_back('{e + 3*T, "R4 abandoned value ignored"});
        idle(35);

        // R8 stop while counting
        base = n_rise;
        cmd(8'h28, e);
        idle(10);
        cmd(8'h29, e);
        idle(40);
        chk(n_rise == base, "R8 stop while counting", n_rise - base, 0);

        // R8 stop during the arming wait
        set_reg(8'h59, 8'd2);
        base = n_rise;
        cmd(8'h28, e);
        idle(5);
        cmd(8'h29, e);
        idle(60);
        chk(n_rise == base, "R8 stop while arming", n_rise - base, 0);
        set_reg(8'h59, 8'd0);

        // R8 refresh while idle
        base = n_rise;
        cmd(8'h2A, e);
        idle(40);
        chk(n_rise == base, "R8 refresh while idle", n_rise - base, 0);

        // R10 zero timeout written while running, then used at next arm
        cmd(8'h28, e);
        fire_q.push_back('{e + 3*T, "R10 running count unchanged"});
        set_reg(8'h5F, 8'd0);
        idle(35);
        cmd(8'h28, e);
        fire_q.push_back('{e + T, "R10 zero timeout one tick"});
        idle(20);

        // R3 high byte: timeout 0x0100
        set_reg(8'h5E, 8'd1);
        cmd(8'h28, e);
        fire_q.push_back('{e + 256*T, "R3 high byte timeout"});
        idle(256*T + 20);

        chk(fire_q.size() == 0, "R5 pulses outstanding", fire_q.size(), 0);
        chk(rd_q.size() == 0, "R2 reads outstanding", rd_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : wdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule